// File: doc/BRIEF.md
# Event-Stepped Counter Bank

This block holds three 16-bit counters that move only when an external state machine reports a state update. The state machine itself is not part of the block. Each update arrives as a one-cycle strobe with two flag bits taken from the state being entered: an "up" flag and a "down" flag. The first counter counts up-flag events. The second counts up-flag events minus down-flag events. The third counts down-flag events down from zero.

A transition back into the same state is still an update, so the strobe and its flags count the same way every time they are presented. Each counter has its own enable and its own clear. A global enable holds the whole bank at zero while it is low. The counter values are register outputs, so they can be read in any cycle.

Top module: `flag_counter_bank`

## Requirements
- R1: After a cycle with `rst_n` low, all three counter outputs read 0.
- R2: Counter A (`cnt_a`, enable and clear bit 0) adds 1 in the cycle after a strobe with `flag_up`=1 while its enable is 1. It is unaffected by `flag_dn`.
- R3: Counter B (`cnt_b`, bit 1) adds 1 on a strobe with only `flag_up` set and subtracts 1 on a strobe with only `flag_dn` set, while its enable is 1.
- R4: Counter B keeps its value on a strobe with both flags set.
- R5: Counter C (`cnt_c`, bit 2) subtracts 1 on a strobe with `flag_dn`=1 while its enable is 1. It is unaffected by `flag_up`.
- R6: All counters wrap modulo 65536. C reads 0xFFFF after its first decrement from 0, and A reads 0 after incrementing from 0xFFFF.
- R7: Every strobe counts, including back-to-back strobes with identical flags (a return to the same state). In a cycle without a strobe, no counter changes.
- R8: A counter whose enable bit is 0 keeps its value on any strobe.
- R9: A set bit in `cnt_clr` zeroes only its own counter on the next edge, and it wins over a count event in the same cycle.
- R10: While `bank_en` is 0, all three counters read 0 after the next edge and ignore strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bank_en | input | 1 | Global enable; 0 holds every counter at zero |
| upd_strobe | input | 1 | One-cycle state-update event |
| flag_up | input | 1 | Up flag of the state being entered |
| flag_dn | input | 1 | Down flag of the state being entered |
| cnt_en | input | 3 | Per-counter enable, bit 0 = A, 1 = B, 2 = C |
| cnt_clr | input | 3 | Per-counter clear, same bit order |
| cnt_a | output | 16 | Counter A value |
| cnt_b | output | 16 | Counter B value |
| cnt_c | output | 16 | Counter C value |

## Verification
A count event and a clear of the same counter can fall in one cycle, and so can a count event and a low global enable. The bench provokes both by sweeping every combination of strobe, flag pair, enable bits, clear bits and global enable, one per cycle. The counters are not cleared between vectors, so earlier counts carry forward. For every vector the bench derives the expected values arithmetically: a zero wherever a clear or a low global enable is present, otherwise the signed step. It then compares all three outputs one cycle later.

// File: rtl/flag_cnt_pkg.sv
// Package flag_cnt_pkg
// Shared types for the counter bank: the per-event step direction and the
// counting rule that a slot of the bank follows.
package flag_cnt_pkg;

    // Direction applied to one counter on one update event.
    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } step_t;

    // Rule that maps the two flags onto a step.
    typedef enum logic [1:0] {
        MODE_UP     = 2'd0,
        MODE_UPDOWN = 2'd1,
        MODE_DOWN   = 2'd2
    } cnt_mode_t;

endpackage

// File: rtl/step_decode.sv
// Module step_decode
// Purely combinational. Turns the up/down flags of the state being entered
// into a step for one counter, following the rule chosen by MODE.
// Assumes the flags are only meaningful together with the update strobe,
// which is qualified elsewhere.
module step_decode
    import flag_cnt_pkg::*;
#(
    parameter cnt_mode_t MODE = MODE_UP
) (
    input  logic  flag_up,
    input  logic  flag_dn,
    output step_t step
);

    generate
        if (MODE == MODE_UP) begin : g_up
            // Count up whenever the up flag is set.
            always_comb step = flag_up ? STEP_UP : STEP_HOLD;
        end else if (MODE == MODE_DOWN) begin : g_down
            // Count down whenever the down flag is set.
            always_comb step = flag_dn ? STEP_DOWN : STEP_HOLD;
        end else begin : g_updown
            // Up or down from one flag; both flags cancel each other.
            always_comb begin
                unique case ({flag_up, flag_dn})
                    2'b10:   step = STEP_UP;
                    2'b01:   step = STEP_DOWN;
                    default: step = STEP_HOLD;
                endcase
            end
        end
    endgenerate

endmodule

// File: rtl/wrap_counter.sv
// Module wrap_counter
// One W-bit register that steps by one in either direction and wraps modulo
// 2^W. Clear has priority over a step. Assumes `advance` is already
// qualified by the update strobe and the counter's enable.
module wrap_counter
    import flag_cnt_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         advance,
    input  step_t        step,
    output logic [W-1:0] value
);

    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    // Register update: reset/clear first, then the step of this event.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            value <= '0;
        end else if (advance) begin
            unique case (step)
                STEP_UP:   value <= value + ONE;
                STEP_DOWN: value <= value - ONE;
                default:   value <= value;
            endcase
        end
    end

    // R9: a clear leaves the register at zero.
    p_clear_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> value == '0);

    // R7: without an event or clear the value is frozen.
    p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!advance && !clear) |=> $stable(value));

    // R6: an up step adds exactly one, wrapping at the top.
    p_up_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !clear && step == STEP_UP) |=> value == W'($past(value) + ONE));

    // R6: a down step subtracts exactly one, wrapping at zero.
    p_down_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !clear && step == STEP_DOWN) |=> value == W'($past(value) - ONE));

endmodule

// File: rtl/flag_counter_bank.sv
// Module flag_counter_bank
// Three counters stepped by state-update events. Slot 0 counts up-flag
// events, slot 1 counts up minus down, slot 2 counts down-flag events.
// Assumes upd_strobe is a one-cycle pulse per update (a repeat of the same
// state is a new pulse) and that the flags are valid in the strobe cycle.
module flag_counter_bank
    import flag_cnt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bank_en,
    input  logic             upd_strobe,
    input  logic             flag_up,
    input  logic             flag_dn,
    input  logic [2:0]       cnt_en,
    input  logic [2:0]       cnt_clr,
    output logic [CNT_W-1:0] cnt_a,
    output logic [CNT_W-1:0] cnt_b,
    output logic [CNT_W-1:0] cnt_c
);

    localparam int NUM_CNT = 3;

    logic [CNT_W-1:0] vals [NUM_CNT];

    generate
        for (genvar i = 0; i < NUM_CNT; i++) begin : g_slot
            localparam cnt_mode_t SLOT_MODE =
                (i == 0) ? MODE_UP : ((i == 1) ? MODE_UPDOWN : MODE_DOWN);

            step_t slot_step;
            logic  slot_clear;
            logic  slot_adv;

            // Clear from the global enable or the slot's own clear bit.
            always_comb slot_clear = !bank_en || cnt_clr[i];
            // An event counts only in a strobe cycle with the slot enabled.
            always_comb slot_adv = upd_strobe && cnt_en[i];

            step_decode #(.MODE(SLOT_MODE)) u_dec (
                .flag_up (flag_up),
                .flag_dn (flag_dn),
                .step    (slot_step)
            );

            wrap_counter #(.W(CNT_W)) u_cnt (
                .clk     (clk),
                .rst_n   (rst_n),
                .clear   (slot_clear),
                .advance (slot_adv),
                .step    (slot_step),
                .value   (vals[i])
            );
        end
    endgenerate

    // Expose the registered counter values.
    assign cnt_a = vals[0];
    assign cnt_b = vals[1];
    assign cnt_c = vals[2];

    // R10: a low global enable zeroes the whole bank.
    p_bank_off_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !bank_en |=> (cnt_a == '0 && cnt_b == '0 && cnt_c == '0));

    // R4: both flags together leave counter B unchanged.
    p_cancel_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_en && !cnt_clr[1] && upd_strobe && flag_up && flag_dn) |=> $stable(cnt_b));

    // R2: counter A never moves downward unless cleared.
    p_a_no_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_en && !cnt_clr[0] && !flag_up) |=> $stable(cnt_a));

    // R5: counter C never moves upward unless cleared.
    p_c_no_up_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_en && !cnt_clr[2] && !flag_dn) |=> $stable(cnt_c));

    // R8: a disabled slot ignores a strobe.
    p_b_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_en && !cnt_clr[1] && !cnt_en[1]) |=> $stable(cnt_b));

endmodule

// File: tb/tb_flag_counter_bank.sv
`timescale 1ns/1ps
module tb_flag_counter_bank;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bank_en;
    logic        upd_strobe;
    logic        flag_up;
    logic        flag_dn;
    logic [2:0]  cnt_en;
    logic [2:0]  cnt_clr;
    logic [15:0] cnt_a, cnt_b, cnt_c;

    int n_vec  = 0;
    int n_fail = 0;
    logic [15:0] exp_v [3];

    always #4 clk = ~clk;

    flag_counter_bank dut (
        .clk(clk), .rst_n(rst_n), .bank_en(bank_en), .upd_strobe(upd_strobe),
        .flag_up(flag_up), .flag_dn(flag_dn), .cnt_en(cnt_en), .cnt_clr(cnt_clr),
        .cnt_a(cnt_a), .cnt_b(cnt_b), .cnt_c(cnt_c)
    );

    task automatic chk(input string req, input string name,
                       input logic [15:0] act, input logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, name, act, exp);
        end
    endtask

    function automatic string tag_for(input int i, input logic b, input logic s,
                                      input logic [2:0] en, input logic [2:0] clr,
                                      input logic u, input logic d);
        if (!b)      return "R10";
        if (clr[i])  return "R9";
        if (!s)      return "R7";
        if (!en[i])  return "R8";
        if (i == 0)  return "R2";
        if (i == 2)  return "R5";
        if (u && d)  return "R4";
        return "R3";
    endfunction

    // Apply one vector from a negedge; the model steps at the posedge.
    task automatic apply(input logic b, input logic s, input logic u, input logic d,
                         input logic [2:0] en, input logic [2:0] clr);
        bank_en = b; upd_strobe = s; flag_up = u; flag_dn = d;
        cnt_en = en; cnt_clr = clr;
        @(posedge clk);
        for (int i = 0; i < 3; i++) begin
            int delta;
            delta = 0;
            if (i == 0) delta = int'(u);
            if (i == 1) delta = int'(u) - int'(d);
            if (i == 2) delta = -int'(d);
            if (!b || clr[i])   exp_v[i] = 16'h0000;
            else if (s && en[i]) exp_v[i] = 16'(int'(exp_v[i]) + delta);
        end
        @(negedge clk);
    endtask

    task automatic check_all(input string req);
        chk(req, "cnt_a", cnt_a, exp_v[0]);
        chk(req, "cnt_b", cnt_b, exp_v[1]);
        chk(req, "cnt_c", cnt_c, exp_v[2]);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; bank_en = 1'b1; upd_strobe = 1'b1; flag_up = 1'b1;
        flag_dn = 1'b0; cnt_en = 3'b111; cnt_clr = 3'b000;
        for (int i = 0; i < 3; i++) exp_v[i] = 16'h0000;
        repeat (3) @(negedge clk);
        // R1: reset state with a strobe active
        check_all("R1");
        rst_n = 1'b1;

        // R6: first C decrement wraps 0 -> FFFF, B too
        apply(1, 1, 0, 1, 3'b111, 3'b000);
        chk("R6", "cnt_c wrap", cnt_c, 16'hFFFF);
        chk("R6", "cnt_b wrap", cnt_b, 16'hFFFF);
        check_all("R6");

        // R7: back-to-back identical strobes (same-state returns) each count
        for (int k = 0; k < 5; k++) begin
            apply(1, 1, 1, 0, 3'b111, 3'b000);
            check_all("R7");
        end
        chk("R7", "cnt_a after 5 repeats", cnt_a, 16'd5);

        // Exhaustive sweep of enable, clear, flags, strobe and global enable
        for (int b = 1; b >= 0; b--)
            for (int en = 0; en < 8; en++)
                for (int clr = 0; clr < 8; clr++)
                    for (int f = 0; f < 4; f++)
                        for (int s = 0; s < 2; s++) begin
                            apply(b[0], s[0], f[1], f[0], en[2:0], clr[2:0]);
                            for (int i = 0; i < 3; i++) begin
                                logic [15:0] act;
                                act = (i == 0) ? cnt_a : ((i == 1) ? cnt_b : cnt_c);
                                chk(tag_for(i, b[0], s[0], en[2:0], clr[2:0], f[1], f[0]),
                                    $sformatf("cnt%0d", i), act, exp_v[i]);
                            end
                        end

        // R6: counter A all the way round from 0
        apply(1, 0, 0, 0, 3'b000, 3'b111);
        check_all("R9");
        for (int k = 0; k < 65535; k++) apply(1, 1, 1, 0, 3'b001, 3'b000);
        chk("R6", "cnt_a top", cnt_a, 16'hFFFF);
        apply(1, 1, 1, 0, 3'b001, 3'b000);
        chk("R6", "cnt_a wrap", cnt_a, 16'h0000);
        check_all("R6");

        finish_run();
    end

endmodule